// File: doc/BRIEF.md
# Read-After-Write Settling Guard

This block sequences a host processor's register accesses onto the bus of an external peripheral. Some of the peripheral's registers only show the effect of a write after a settling time, and that time differs from register to register. The guard notes when the last write strobe ended. When a host read comes directly after a host write, the guard holds the read back until that register's settling time has passed.

The wait can be covered in one of two ways, chosen by `dummy_mode`. In stall mode the bus stays quiet. In dummy mode the guard sends back-to-back reads to a test-pattern register that has no side effects and needs no settling time. The data from those reads is thrown away. A read that comes after another read passes straight through. A read is also sent at once if enough time has already passed since the write.

Requests use a valid/ready handshake. `host_ready` is high only while the guard is idle. A request is taken on a clock edge where `host_valid` and `host_ready` are both high. The host must keep `host_we`, `host_idx` and `host_wdata` steady while it waits. The read response is a single-cycle pulse with no back-pressure, so the host must always be able to take it.

Top module: `raw_guard`

## Requirements
- R1: A request is accepted on a rising edge where `host_valid` and `host_ready` are both high. `host_ready` is high after reset and whenever no access is in progress, and it is low from acceptance until the access has finished. While it is low, no new request, including a write, is accepted.
- R2: Every peripheral access holds its strobe for ACC = ceil(BUS_NS/CLK_NS) consecutive clocks, which is 3 with the defaults of 45 ns and 20 ns. A write drives `per_wr` with `per_addr` = index and `per_wdata` = host data. `per_rd` and `per_wr` are never high together.
- R3: For each host read, `rsp_valid` pulses for one cycle, in the cycle after the last read-strobe cycle. `rsp_data` carries the `per_rdata` value sampled in that last strobe cycle.
- R4: Settling times by 5-bit index: 0 ns for 0, 4 and 10; 90 ns for 2; 135 ns for 1, 11 and 15; 180 ns for 17; 315 ns for 12 and for every index from 18 to 31; 45 ns for 3, 5 to 9, 13, 14 and 16. In clocks the wait is ceil(ns/CLK_NS), which gives 0, 3, 5, 7, 9 or 16.
- R5: When the previous completed host access was a write, a host read strobe begins only when the number of clock cycles strictly between the last write-strobe cycle and the first read-strobe cycle is at least the wait of that index.
- R6: When the previous completed host access was a read, a read strobe begins in the cycle after acceptance, whatever the index.
- R7: If the wait is already satisfied, the read strobe begins in the cycle after acceptance, with no idle cycles and no dummy reads.
- R8: With `dummy_mode`=0, the bus carries no strobe while a read waits. The read begins in the earliest cycle that both meets R5 and comes after acceptance.
- R9: With `dummy_mode`=1, the guard issues dummy reads to index 4 back to back, each ACC clocks long, starting the cycle after acceptance. It stops as soon as the host read can start under R5. Dummy reads produce no `rsp_valid`.
- R10: The elapsed count restarts after every write and saturates at the largest wait, 16 clocks. A read issued long after a write is therefore never delayed.
- R11: Reset (active-low `rst_n`) leaves `host_ready` high, `per_rd`, `per_wr` and `rsp_valid` low, and no write on record, so the first read is not delayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dummy_mode | input | 1 | 1: cover waits with dummy reads; 0: stall |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Guard can accept a request |
| host_we | input | 1 | 1: write, 0: read |
| host_idx | input | 5 | Register index |
| host_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 16 | Read data |
| per_rd | output | 1 | Peripheral read strobe |
| per_wr | output | 1 | Peripheral write strobe |
| per_addr | output | 5 | Peripheral register index |
| per_wdata | output | 16 | Peripheral write data |
| per_rdata | input | 16 | Peripheral read data |

## Verification
The assertions assume the host keeps its request fields and `dummy_mode` steady from the moment it raises `host_valid` until acceptance. They also assume the peripheral returns data combinationally while `per_rd` is high. The bench drives each request on a falling edge, keeps it untouched until it sees `host_ready` high, and changes the mode only between requests, while the guard is idle. The modelled peripheral answers every read with a pattern built from `per_addr`, so any dummy data that leaks to the host shows up as an extra or wrong response.

// File: rtl/raw_guard_pkg.sv
package raw_guard_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_STALL, ST_DUMMY, ST_XFER} bus_state_e;

  function automatic int unsigned ceil_div(int unsigned num, int unsigned den);
    return (num + den - 1) / den;
  endfunction

  // settling time in ns after any write, per register index
  function automatic int unsigned settle_ns(int unsigned idx);
    case (idx)
      0, 4, 10:                     return 0;
      2:                            return 90;
      1, 11, 15:                    return 135;
      17:                           return 180;
      3, 5, 6, 7, 8, 9, 13, 14, 16: return 45;
      default:                      return 315;
    endcase
  endfunction

endpackage

// File: rtl/raw_wait_table.sv
module raw_wait_table
  import raw_guard_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int CLK_NS = 20,
  parameter int CNT_W  = 5
) (
  input  logic [IDX_W-1:0] idx,
  output logic [CNT_W-1:0] wait_clks
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [CNT_W-1:0] rom [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_rom
    assign rom[g] = CNT_W'(ceil_div(settle_ns(g), CLK_NS));
  end

  assign wait_clks = rom[idx];
endmodule

// File: rtl/raw_elapsed_timer.sv
module raw_elapsed_timer #(
  parameter int CNT_W    = 5,
  parameter int MAX_CLKS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_done,
  input  logic             rd_done,
  output logic [CNT_W-1:0] elapsed,
  output logic             armed
);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_CLKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= MAX_V;
      armed   <= 1'b0;
    end else begin
      if (wr_done)              elapsed <= '0;
      else if (elapsed < MAX_V) elapsed <= elapsed + 1'b1;
      if (wr_done)      armed <= 1'b1;
      else if (rd_done) armed <= 1'b0;
    end
  end

  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    elapsed <= MAX_V);
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> (elapsed == '0) && armed);
endmodule

// File: rtl/raw_bus_fsm.sv
module raw_bus_fsm
  import raw_guard_pkg::*;
#(
  parameter int IDX_W    = 5,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 5,
  parameter int ACC_CLKS = 3,
  parameter int TEST_IDX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dummy_mode,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              per_rd,
  output logic              per_wr,
  output logic [IDX_W-1:0]  per_addr,
  output logic [DATA_W-1:0] per_wdata,
  input  logic [DATA_W-1:0] per_rdata,
  output logic [IDX_W-1:0]  lookup_idx,
  input  logic [CNT_W-1:0]  wait_clks,
  input  logic [CNT_W-1:0]  elapsed,
  input  logic              armed,
  output logic              wr_done,
  output logic              rd_done
);
  localparam int ACC_W = $clog2(ACC_CLKS + 1);
  localparam logic [ACC_W-1:0] ACC_LAST = ACC_W'(ACC_CLKS - 1);

  bus_state_e        state;
  logic [ACC_W-1:0]  cnt;
  logic              req_we;
  logic [IDX_W-1:0]  req_idx;
  logic [DATA_W-1:0] req_wdata;
  logic [CNT_W:0]    el_next;
  logic              clear_next;
  logic              last_beat;

  // the lookup must serve the live request while idle
  assign lookup_idx = (state == ST_IDLE) ? host_idx : req_idx;
  // elapsed value in the cycle a strobe launched now would start
  assign el_next    = {1'b0, elapsed} + 1'b1;
  assign clear_next = !armed || (el_next >= {1'b0, wait_clks});
  assign last_beat  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      req_we    <= 1'b0;
      req_idx   <= '0;
      req_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (host_valid) begin
          req_we    <= host_we;
          req_idx   <= host_idx;
          req_wdata <= host_wdata;
          cnt       <= ACC_LAST;
          if (host_we || clear_next) state <= ST_XFER;
          else if (dummy_mode)       state <= ST_DUMMY;
          else                       state <= ST_STALL;
        end
        ST_STALL: if (clear_next) begin
          state <= ST_XFER;
          cnt   <= ACC_LAST;
        end
        ST_DUMMY: if (last_beat) begin
          cnt <= ACC_LAST;
          if (clear_next) state <= ST_XFER;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: if (last_beat) state <= ST_IDLE;
                 else           cnt   <= cnt - 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_done;
      if (rd_done) rsp_data <= per_rdata;
    end
  end

  assign host_ready = (state == ST_IDLE);
  assign wr_done    = (state == ST_XFER) && last_beat && req_we;
  assign rd_done    = (state == ST_XFER) && last_beat && !req_we;
  assign per_rd     = (state == ST_DUMMY) || ((state == ST_XFER) && !req_we);
  assign per_wr     = (state == ST_XFER) && req_we;
  assign per_addr   = (state == ST_DUMMY) ? IDX_W'(TEST_IDX) : req_idx;
  assign per_wdata  = req_wdata;

  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(per_rd && per_wr));
  a_r5_settled: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_XFER) && !req_we && (cnt == ACC_LAST) && armed)
      |-> (elapsed >= wait_clks));
  a_r9_dummy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DUMMY) |-> armed);
  a_r3_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(per_rd && (per_addr == req_idx) && (state == ST_XFER)));
  a_r1_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ready && host_valid) |=> !host_ready);
endmodule

// File: rtl/raw_guard.sv
module raw_guard
  import raw_guard_pkg::*;
#(
  parameter int IDX_W    = 5,
  parameter int DATA_W   = 16,
  parameter int CLK_NS   = 20,
  parameter int BUS_NS   = 45,
  parameter int TEST_IDX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dummy_mode,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              per_rd,
  output logic              per_wr,
  output logic [IDX_W-1:0]  per_addr,
  output logic [DATA_W-1:0] per_wdata,
  input  logic [DATA_W-1:0] per_rdata
);
  localparam int MAX_CLKS = ceil_div(315, CLK_NS);
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);
  localparam int ACC_RAW  = ceil_div(BUS_NS, CLK_NS);
  localparam int ACC_CLKS = (ACC_RAW < 1) ? 1 : ACC_RAW;

  logic [IDX_W-1:0] lookup_idx;
  logic [CNT_W-1:0] wait_clks;
  logic [CNT_W-1:0] elapsed;
  logic             armed;
  logic             wr_done;
  logic             rd_done;

  raw_wait_table #(.IDX_W(IDX_W), .CLK_NS(CLK_NS), .CNT_W(CNT_W)) u_table (
    .idx(lookup_idx), .wait_clks(wait_clks)
  );

  raw_elapsed_timer #(.CNT_W(CNT_W), .MAX_CLKS(MAX_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .rd_done(rd_done),
    .elapsed(elapsed), .armed(armed)
  );

  raw_bus_fsm #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .ACC_CLKS(ACC_CLKS), .TEST_IDX(TEST_IDX)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .dummy_mode(dummy_mode),
    .host_valid(host_valid), .host_ready(host_ready), .host_we(host_we),
    .host_idx(host_idx), .host_wdata(host_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .per_rd(per_rd), .per_wr(per_wr), .per_addr(per_addr),
    .per_wdata(per_wdata), .per_rdata(per_rdata),
    .lookup_idx(lookup_idx), .wait_clks(wait_clks), .elapsed(elapsed),
    .armed(armed), .wr_done(wr_done), .rd_done(rd_done)
  );
endmodule

// File: tb/raw_guard_test.sv
module raw_guard_test;
  localparam int ACC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dummy_mode = 1'b0;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic        host_we = 1'b0;
  logic [4:0]  host_idx = '0;
  logic [15:0] host_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        per_rd, per_wr;
  logic [4:0]  per_addr;
  logic [15:0] per_wdata;
  logic [15:0] per_rdata;

  int tests = 0, fails = 0;
  int cyc = 0;
  int last_wr_seen = -1;
  int read_start = -1;
  int dummy_cyc = 0;
  int wr_run = 0, rd_run = 0;
  int last_wr_model = 0;
  bit armed_m = 1'b0;
  logic [15:0] exp_wdata = '0;
  logic [15:0] sbq [$];
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  // peripheral model: read data is a pattern of the address
  assign per_rdata = per_rd ? (16'h5A00 | {11'd0, per_addr}) : 16'h0000;

  raw_guard uut (
    .clk(clk), .rst_n(rst_n), .dummy_mode(dummy_mode),
    .host_valid(host_valid), .host_ready(host_ready), .host_we(host_we),
    .host_idx(host_idx), .host_wdata(host_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .per_rd(per_rd), .per_wr(per_wr), .per_addr(per_addr),
    .per_wdata(per_wdata), .per_rdata(per_rdata)
  );

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int wclk(int idx);
    int ns;
    case (idx)
      0, 4, 10: ns = 0;
      2: ns = 90;
      1, 11, 15: ns = 135;
      17: ns = 180;
      3, 5, 6, 7, 8, 9, 13, 14, 16: ns = 45;
      default: ns = 315;
    endcase
    return (ns + 19) / 20;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: bus activity and scoreboard of responses
  always @(negedge clk) if (rst_n) begin
    check(!(per_rd && per_wr), "R2 strobes exclusive", int'(per_rd), 0);
    if (per_wr) begin
      last_wr_seen = cyc;
      wr_run++;
      if (wr_run == 1) check(per_wdata == exp_wdata, "R2 write data", per_wdata, exp_wdata);
    end else if (wr_run != 0) begin
      check(wr_run == ACC, "R2 write strobe length", wr_run, ACC);
      wr_run = 0;
    end
    if (per_rd) begin
      rd_run++;
      if (per_addr == 5'd4) dummy_cyc++;
      else if (read_start < 0) read_start = cyc;
    end else if (rd_run != 0) begin
      check(rd_run % ACC == 0, "R2 read strobe length", rd_run, ACC);
      rd_run = 0;
    end
    if (rsp_valid) begin
      if (sbq.size() == 0) check(1'b0, "R3 unexpected response", rsp_data, 0);
      else begin
        logic [15:0] e;
        e = sbq.pop_front();
        check(rsp_data == e, "R3 response data", rsp_data, e);
      end
    end
  end

  // caller is at a falling edge; returns at a falling edge
  task automatic host_op(bit we, logic [4:0] idx, logic [15:0] d, output int acc);
    host_we = we; host_idx = idx; host_wdata = d; host_valid = 1'b1;
    while (!host_ready) @(negedge clk);
    acc = cyc;
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!host_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(logic [4:0] idx, logic [15:0] d);
    int acc;
    exp_wdata = d;
    host_op(1'b1, idx, d, acc);
    wait_idle();
    last_wr_model = acc + ACC;
    check(last_wr_seen == last_wr_model, "R2 write timing", last_wr_seen, last_wr_model);
    armed_m = 1'b1;
  endtask

  task automatic do_read(logic [4:0] idx, bit dm, string req);
    int acc, d0, need, earliest, exp_start, exp_d, n;
    dummy_mode = dm;
    sbq.push_back(16'h5A00 | {11'd0, idx});
    d0 = dummy_cyc;
    read_start = -1;
    host_op(1'b0, idx, 16'h0, acc);
    check(host_ready == 1'b0, "R1 busy while read pending", int'(host_ready), 0);
    wait_idle();
    need = armed_m ? wclk(idx) : 0;
    earliest = last_wr_model + 1 + need;
    exp_d = 0;
    if (!armed_m || acc + 1 >= earliest) exp_start = acc + 1;
    else if (!dm) exp_start = earliest;
    else begin
      n = (earliest - acc - 1 + ACC - 1) / ACC;
      exp_start = acc + 1 + ACC * n;
      exp_d = n;
    end
    check(read_start == exp_start, {req, " read start"}, read_start, exp_start);
    check(dummy_cyc - d0 == ACC * exp_d, {req, " dummy cycles"}, dummy_cyc - d0, ACC * exp_d);
    armed_m = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(host_ready == 1'b1, "R11 ready in reset", int'(host_ready), 1);
    check(!per_rd && !per_wr, "R11 strobes low", int'(per_rd | per_wr), 0);
    check(rsp_valid == 1'b0, "R11 no response", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(host_ready == 1'b1, "R1 ready after reset", int'(host_ready), 1);

    do_read(5'd12, 1'b0, "R11 first read undelayed");
    do_write(5'd5, 16'hBEEF);
    do_read(5'd12, 1'b0, "R8 stall longest wait");
    do_read(5'd12, 1'b0, "R6 read after read");
    do_write(5'd6, 16'h1234);
    do_read(5'd0, 1'b0, "R7 zero wait");
    do_write(5'd7, 16'h0F0F);
    do_read(5'd1, 1'b0, "R4 R8 fifo level wait");
    do_write(5'd8, 16'hA5A5);
    do_read(5'd25, 1'b0, "R4 out of range index");
    do_write(5'd9, 16'h5555);
    do_read(5'd12, 1'b1, "R9 dummy longest");
    do_write(5'd13, 16'h7777);
    do_read(5'd17, 1'b1, "R9 dummy 180ns");
    do_write(5'd14, 16'h3333);
    do_read(5'd2, 1'b1, "R9 dummy 90ns");
    do_write(5'd16, 16'h2222);
    do_read(5'd3, 1'b1, "R9 dummy 45ns");
    do_write(5'd3, 16'h9999);
    repeat (4) @(negedge clk);
    do_read(5'd11, 1'b0, "R5 partial idle stall");
    do_write(5'd3, 16'h8888);
    repeat (2) @(negedge clk);
    do_read(5'd15, 1'b1, "R5 partial idle dummy");
    do_write(5'd2, 16'h4444);
    repeat (25) @(negedge clk);
    do_read(5'd12, 1'b1, "R10 saturated elapsed");
    do_write(5'd1, 16'h6666);
    do_write(5'd1, 16'h6767);
    do_read(5'd12, 1'b0, "R10 restart on second write");
    do_read(5'd31, 1'b1, "R6 read after read dummy mode");

    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "R3 all responses seen", sbq.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule